// File: doc/BRIEF.md
# Converter Serial Control and Readout Port

This block is the serial side of a multichannel sampling converter. A host writes a five-bit control word through a data input, framed by an active-low transmit strobe. It reads back a sixteen-bit result word on a data output, framed by an active-low receive strobe. The result word holds a leading zero, the three channel-address bits from the control register and the twelve conversion bits. The converter core passes each result to the port as a parallel word with a valid pulse. The port returns the control register, and the core uses it to pick the channel and the output coding.

A role input selects who owns the serial clock. In slave role the serial clock and the receive strobe come from outside. They are synchronised into the system clock domain, and their edges are detected there. In master role the port builds the serial clock by dividing the system clock by two and drives the receive strobe itself. A one-cycle read request starts each master frame. If the transmit strobe is tied to the receive strobe, one frame can write the control register and read a result at the same time.

Top module: `adc_serial_port`

## Requirements
- R1: The readout word is sent MSB first as {1'b0, addr[2:0], data[11:0]}, where addr is ctrl_word[4:2]. The address and data are captured when the frame starts, so a write completed later in the same frame does not appear in that frame.
- R2: Each readout bit is valid on dout at one falling serial-clock edge, for sixteen falling edges after the receive strobe goes low. After the sixteenth edge dout is 0 until the next frame.
- R3: With the transmit strobe low, the first five falling serial-clock edges shift din into a staging register, MSB first. ctrl_word takes the five bits only once the fifth bit has arrived. A frame that ends with fewer than five bits leaves ctrl_word unchanged. Field layout: ctrl_word[4:2] address, ctrl_word[1] coding select, ctrl_word[0] auxiliary bit.
- R4: Falling edges after the fifth are ignored while the transmit strobe stays low. Edges while the transmit strobe is high are ignored. Raising the transmit strobe restarts the bit count.
- R5: In master role (slave_mode=0), sclk_out is high while idle. A rd_start seen while idle starts a frame on the next clock: rfs_out_n goes low for exactly 32 clocks. During that time sclk_out starts high and toggles on every clock, which gives 16 falling edges.
- R6: In slave role (slave_mode=1), sclk_in and rfs_in_n frame the readout, rd_start is ignored, and rfs_out_n and sclk_out stay high.
- R7: With ctrl_word[1]=0 the data field is the result in straight binary. With ctrl_word[1]=1 the MSB of the result is inverted, which gives two's complement.
- R8: In master role, tfs_n and din are sampled on the clock edge where sclk_out falls. Tying tfs_n to rfs_out_n lets one frame write the control register and read a result.
- R9: A result that arrives while a readout frame is in progress is held and moved into the output register when the frame ends. A result that arrives while idle is taken on the next clock. If several results arrive during one frame, the newest is kept.
- R10: After reset, ctrl_word is 0, dout is 0, and rfs_out_n and sclk_out are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the master serial clock is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1 = serial clock and receive strobe from outside, 0 = driven by the port |
| sclk_in | input | 1 | External serial clock (slave role) |
| rfs_in_n | input | 1 | External active-low receive strobe (slave role) |
| tfs_n | input | 1 | Active-low transmit strobe framing control writes |
| din | input | 1 | Serial control data, MSB first |
| rd_start | input | 1 | Starts a master readout frame when idle |
| conv_valid | input | 1 | One-cycle pulse: conv_data holds a new result |
| conv_data | input | 12 | Conversion result, straight binary |
| sclk_out | output | 1 | Master serial clock, system clock divided by two |
| rfs_out_n | output | 1 | Master active-low receive strobe |
| dout | output | 1 | Serial readout data |
| ctrl_word | output | 5 | Control register |

## Verification
The bench writes words that carry extra trailing bits, to catch a register that keeps shifting after the fifth bit. It also writes a word that stops after three bits, to catch a design that updates the address bit by bit. It sends a new result in the middle of a readout frame. A port that updates its output register at once would tear that frame. One that drops the pending result would then read back stale data. A tied-strobe master frame rewrites the address while the port is reading. A design that snapshots the address late would report the new channel, and a wrong divider or frame length would show up in the per-clock comparison of sclk_out, rfs_out_n and dout.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;
  typedef enum logic {
    ROLE_MASTER = 1'b0,
    ROLE_SLAVE  = 1'b1
  } sport_role_e;

  localparam int LEAD_ZERO_W = 1;
  localparam int EXTRA_CTRL_W = 2;
endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
          chain_q[0] <= d;
          for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sport_master_gen.sv
module sport_master_gen #(
  parameter int BITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  output logic sclk_q,
  output logic rfs_n_q,
  output logic active_q,
  output logic wr_pulse,
  output logic sh_pulse,
  output logic load_pulse
);
  localparam int HW = $clog2(2 * BITS);
  localparam logic [HW-1:0] LAST = HW'(2 * BITS - 1);

  logic [HW-1:0] h_q;

  assign load_pulse = en & start & ~active_q;
  assign wr_pulse   = active_q & ~h_q[0];
  assign sh_pulse   = active_q & h_q[0] & (h_q != LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active_q <= 1'b0;
      h_q      <= '0;
      sclk_q   <= 1'b1;
      rfs_n_q  <= 1'b1;
    end else if (load_pulse) begin
      active_q <= 1'b1;
      h_q      <= '0;
      sclk_q   <= 1'b1;
      rfs_n_q  <= 1'b0;
    end else if (active_q) begin
      if (h_q == LAST) begin
        active_q <= 1'b0;
        h_q      <= '0;
        sclk_q   <= 1'b1;
        rfs_n_q  <= 1'b1;
      end else begin
        h_q    <= h_q + 1'b1;
        sclk_q <= h_q[0];
      end
    end
  end

  // R5: serial clock toggles every clock while the strobe stays low
  p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (!rfs_n_q && $past(!rfs_n_q)) |-> (sclk_q != $past(sclk_q)));
  // R5: serial clock idles high
  p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
    rfs_n_q |-> sclk_q);
  // R5: strobe released after the last half period
  p_frame_end_r5: assert property (@(posedge clk) disable iff (rst)
    (active_q && h_q == LAST) |=> rfs_n_q);
endmodule

// File: rtl/sport_ctrl_rx.sv
module sport_ctrl_rx #(
  parameter int CTRL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              wr_pulse,
  input  logic              bit_in,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam int CW = $clog2(CTRL_W + 1);
  localparam logic [CW-1:0] FULL = CW'(CTRL_W);
  localparam logic [CW-1:0] LAST = CW'(CTRL_W - 1);

  logic [CW-1:0]     cnt_q;
  logic [CTRL_W-1:0] stage_q;
  logic [CTRL_W-1:0] stage_nx;

  assign stage_nx = {stage_q[CTRL_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      stage_q <= '0;
      ctrl_q  <= '0;
    end else if (frame_n) begin
      cnt_q <= '0;
    end else if (wr_pulse && cnt_q < FULL) begin
      stage_q <= stage_nx;
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == LAST) ctrl_q <= stage_nx;
    end
  end

  // R3: the control register changes only when the fifth bit lands
  p_commit_once_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q != $past(ctrl_q)) |-> ($past(cnt_q) == LAST));
  // R4: once five bits are in, the staging register no longer moves
  p_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL) |=> $stable(stage_q));
endmodule

// File: rtl/sport_readout.sv
module sport_readout #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              busy,
  input  logic              load,
  input  logic              shift,
  input  logic [ADDR_W-1:0] addr,
  input  logic              twos,
  output logic              dout
);
  import adc_sport_pkg::*;
  localparam int WORD_W = LEAD_ZERO_W + ADDR_W + DATA_W;
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);

  logic [DATA_W-1:0] result_q, pend_q, coded;
  logic              pend_v_q;
  logic [WORD_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;

  assign coded = twos ? {~result_q[DATA_W-1], result_q[DATA_W-2:0]} : result_q;
  assign dout  = sh_q[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (busy) begin
      if (conv_valid) begin
        pend_q   <= conv_data;
        pend_v_q <= 1'b1;
      end
    end else begin
      if (conv_valid) result_q <= conv_data;
      else if (pend_v_q) result_q <= pend_q;
      pend_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= {{LEAD_ZERO_W{1'b0}}, addr, coded};
      cnt_q <= '0;
    end else if (shift && cnt_q < FULL) begin
      sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end else if (!busy) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end
  end

  // R9: output register frozen across a running frame
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(result_q));
  // R2: line is zero after the sixteenth bit
  p_tail_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL) |-> !dout);
  // R1: first bit of every frame is the leading zero
  p_lead_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> !dout);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W = ADDR_W + adc_sport_pkg::EXTRA_CTRL_W,
  localparam int WORD_W = adc_sport_pkg::LEAD_ZERO_W + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slave_mode,
  input  logic              sclk_in,
  input  logic              rfs_in_n,
  input  logic              tfs_n,
  input  logic              din,
  input  logic              rd_start,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  output logic              sclk_out,
  output logic              rfs_out_n,
  output logic              dout,
  output logic [CTRL_W-1:0] ctrl_word
);
  import adc_sport_pkg::*;

  sport_role_e role;
  logic is_slave;
  assign role     = sport_role_e'(slave_mode);
  assign is_slave = (role == ROLE_SLAVE);

  logic s_sclk, s_rfs_n, s_tfs_n, s_din;
  sport_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk_in, rfs_in_n, tfs_n, din}),
    .q   ({s_sclk, s_rfs_n, s_tfs_n, s_din})
  );

  logic sclk_d_q, rfs_d_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d_q <= 1'b1;
      rfs_d_q  <= 1'b1;
    end else begin
      sclk_d_q <= s_sclk;
      rfs_d_q  <= s_rfs_n;
    end
  end

  logic s_fall, s_load;
  assign s_fall = sclk_d_q & ~s_sclk;
  assign s_load = rfs_d_q & ~s_rfs_n;

  logic m_active, m_wr, m_sh, m_load;
  sport_master_gen #(.BITS(WORD_W)) u_mgen (
    .clk        (clk),
    .rst        (rst),
    .en         (~is_slave),
    .start      (rd_start),
    .sclk_q     (sclk_out),
    .rfs_n_q    (rfs_out_n),
    .active_q   (m_active),
    .wr_pulse   (m_wr),
    .sh_pulse   (m_sh),
    .load_pulse (m_load)
  );

  logic wr_pulse, frame_n, wr_bit;
  assign wr_pulse = is_slave ? s_fall : m_wr;
  assign frame_n  = is_slave ? s_tfs_n : tfs_n;
  assign wr_bit   = is_slave ? s_din : din;

  sport_ctrl_rx #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .wr_pulse (wr_pulse),
    .bit_in   (wr_bit),
    .ctrl_q   (ctrl_word)
  );

  logic rd_busy, rd_load, rd_shift;
  assign rd_busy  = is_slave ? ~s_rfs_n : m_active;
  assign rd_load  = is_slave ? s_load : m_load;
  assign rd_shift = is_slave ? (s_fall & ~s_rfs_n) : m_sh;

  sport_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .conv_valid (conv_valid),
    .conv_data  (conv_data),
    .busy       (rd_busy),
    .load       (rd_load),
    .shift      (rd_shift),
    .addr       (ctrl_word[CTRL_W-1 -: ADDR_W]),
    .twos       (ctrl_word[1]),
    .dout       (dout)
  );

  // R6: slave role keeps the master outputs parked high
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (slave_mode && $past(slave_mode)) |-> (rfs_out_n && sclk_out));
endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst, slave_mode, sclk_in, rfs_in_n, tfs_drv, tie, din, rd_start, conv_valid;
  logic [11:0] conv_data;
  logic sclk_out, rfs_out_n, dout;
  logic [4:0] ctrl_word;
  logic tfs_w;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int low_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tfs_w = tie ? rfs_out_n : tfs_drv;

  adc_serial_port dut (
    .clk(clk), .rst(rst), .slave_mode(slave_mode), .sclk_in(sclk_in),
    .rfs_in_n(rfs_in_n), .tfs_n(tfs_w), .din(din), .rd_start(rd_start),
    .conv_valid(conv_valid), .conv_data(conv_data), .sclk_out(sclk_out),
    .rfs_out_n(rfs_out_n), .dout(dout), .ctrl_word(ctrl_word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R5: strobe length measured independently
  always @(negedge clk) begin
    if (!rst) begin
      if (!rfs_out_n) low_cnt++;
      else begin
        if (low_cnt != 0) chk(low_cnt == 32, "R5 strobe length", low_cnt, 32);
        low_cnt = 0;
      end
    end
  end

  task automatic conv(input logic [11:0] d);
    conv_data = d; conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
  endtask

  task automatic slave_write(input logic [15:0] bits, input int n);
    tfs_drv = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      din = bits[15-k];
      repeat (HALF) @(negedge clk);
      sclk_in = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk_in = 1'b1;
    end
    tfs_drv = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic slave_idle_edges(input int n);
    for (int k = 0; k < n; k++) begin
      din = k[0];
      repeat (HALF) @(negedge clk);
      sclk_in = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk_in = 1'b1;
    end
  endtask

  task automatic slave_read(input logic [15:0] exp, input int mid, input logic [11:0] mid_d);
    rfs_in_n = 1'b0;
    for (int k = 0; k < 17; k++) begin
      repeat (HALF) @(negedge clk);
      if (k < 16) chk(dout == exp[15-k], "R1/R2 slave bit", dout, exp[15-k]);
      else chk(dout == 1'b0, "R2 tail zero", dout, 0);
      sclk_in = 1'b0;
      if (k == mid) conv(mid_d); else @(negedge clk);
      repeat (HALF-1) @(negedge clk);
      sclk_in = 1'b1;
    end
    rfs_in_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  // master frame: per-clock comparison against the expected waveform
  task automatic master_frame(input logic [15:0] exp, input logic [4:0] wbits, input bit tied);
    tie = tied; tfs_drv = 1'b1;
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i > 0) @(negedge clk);
      chk(rfs_out_n == 1'b0, "R5 strobe low", rfs_out_n, 0);
      chk(sclk_out == (i % 2 == 0), "R5 divided clock", sclk_out, (i % 2 == 0));
      chk(dout == exp[15 - i/2], "R1 master bit", dout, exp[15 - i/2]);
      if (i % 2 == 0) din = (i/2 < 5) ? wbits[4 - i/2] : 1'b0;
    end
    @(negedge clk);
    chk(rfs_out_n && sclk_out, "R5 idle after frame", {rfs_out_n, sclk_out}, 3);
    tie = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; slave_mode = 1'b1; sclk_in = 1'b1; rfs_in_n = 1'b1; tfs_drv = 1'b1;
    tie = 1'b0; din = 1'b0; rd_start = 1'b0; conv_valid = 1'b0; conv_data = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctrl_word == 5'b0 && dout == 1'b0, "R10 reset data", {ctrl_word, dout}, 0);
    chk(rfs_out_n && sclk_out, "R10 reset strobes", {rfs_out_n, sclk_out}, 3);

    // R3: five-bit slave write
    slave_write(16'b10100_00000000000, 5);
    chk(ctrl_word == 5'b10100, "R3 write", ctrl_word, 5'b10100);

    // R1/R9: read, new result mid-frame must not tear it
    conv(12'hA5C);
    @(negedge clk);
    slave_read(16'h5A5C, 5, 12'h123);
    slave_read(16'h5123, 99, 12'h0);

    // R4: extra bits past the fifth are ignored
    slave_write(16'b01110_10101_000000, 10);
    chk(ctrl_word == 5'b01110, "R4 extra bits ignored", ctrl_word, 5'b01110);

    // R7: two's complement coding
    conv(12'h800);
    @(negedge clk);
    slave_read(16'h3000, 99, 12'h0);
    conv(12'h7FF);
    @(negedge clk);
    slave_read(16'h3FFF, 99, 12'h0);

    // R3: short write leaves register alone; R4: edges with strobe high ignored
    slave_write(16'b111_0000000000000, 3);
    chk(ctrl_word == 5'b01110, "R3 short write", ctrl_word, 5'b01110);
    slave_idle_edges(6);
    chk(ctrl_word == 5'b01110, "R4 strobe high", ctrl_word, 5'b01110);

    // R6: rd_start ignored in slave role
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rfs_out_n && sclk_out, "R6 slave quiet", {rfs_out_n, sclk_out}, 3);
    end

    // R5/R8: master frame with tied strobes writes and reads together
    slave_mode = 1'b0;
    repeat (3) @(negedge clk);
    master_frame(16'h3FFF, 5'b10001, 1'b1);
    chk(ctrl_word == 5'b10001, "R8 tied write", ctrl_word, 5'b10001);
    master_frame(16'h47FF, 5'b00000, 1'b0);
    chk(ctrl_word == 5'b10001, "R8 untied no write", ctrl_word, 5'b10001);

    slave_mode = 1'b1;
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule